// File: doc/BRIEF.md
# Card Data FIFO with Clock-Stall Control

This block is the byte buffer between a host bus and a serial memory-card data engine. It holds up to 16 bytes. In the transmit direction the host fills the buffer and the engine takes one byte at a time to shift out to the card. In the receive direction the engine deposits bytes arriving from the card without any host action, and the host drains them. A transfer is armed with a start command that carries a byte count. When the count runs out the transfer ends, the block returns to idle and it gives a one-cycle completion pulse.

The block never drops or overwrites data. Suppose the engine asks for a byte while the buffer is empty, or offers a byte while the buffer is full. The block then gates the card clock off and holds the transfer there. Once the host has written a byte (transmit) or read a byte (receive), the stall clears, the clock returns and a sticky resume flag is raised for that direction. The engine raises its request only at a byte boundary, so the clock is never gated in the middle of a byte.

All data paths use valid/ready. A beat moves only in a cycle where both valid and ready are high. A source holds its data steady until the beat is taken, and a sink may hold ready low for any number of cycles. If the host offers a write that is refused, or asks for a read that is refused, the attempt has no effect and is reported by an error pulse.

Top module: `card_fifo_stall`

## Requirements
- R1: The host write port accepts a byte when `host_wr_valid` and `host_wr_ready` are both high. `host_wr_ready` is high exactly when the buffer holds fewer than 16 bytes and no receive transfer is active. Bytes leave the buffer in the order they were stored.
- R2: `host_rd_valid` is high exactly when the buffer is non-empty and no transmit transfer is active. `host_rd_data` shows the oldest byte, and a beat (`host_rd_valid` and `host_rd_ready`) removes that byte.
- R3: A host write offered while `host_wr_ready` is low leaves the buffer unchanged and makes `wr_err` high for the next cycle. A host read requested while `host_rd_valid` is low leaves the buffer unchanged and makes `rd_err` high for the next cycle.
- R4: In idle, a `start_tx` with a non-zero `xfer_len` makes `tx_active` high from the next cycle. A `start_rx` does the same for `rx_active`. If both are given together, `start_tx` wins. A zero length, or a start given while a transfer is active, is ignored. The two active outputs are never high together.
- R5: During a transmit transfer, `eng_tx_valid` is high exactly when the buffer is non-empty and the transfer is not stalled. `eng_tx_data` is the oldest byte, and each engine beat removes one byte.
- R6: If the engine raises `eng_tx_ready` while the buffer is empty during a transmit transfer, the transfer stalls and `card_clk_en` goes low from the next cycle. `card_clk_en` falls during a transfer only after such an engine request.
- R7: Once a stalled transmit transfer sees a non-empty buffer, the stall clears on the next edge and `tx_resume` is set.
- R8: During a receive transfer, `eng_rx_ready` is high exactly when the buffer is not full and the transfer is not stalled. Each engine beat stores `eng_rx_data`.
- R9: If the engine raises `eng_rx_valid` while the buffer is full during a receive transfer, the transfer stalls and `card_clk_en` goes low. Once the buffer is no longer full, the stall clears on the next edge and `rx_resume` is set.
- R10: Each engine beat lowers the remaining count by one. The beat that takes the count to zero ends the transfer: in the next cycle the active output is low and `xfer_done` is high for that one cycle.
- R11: `tx_resume` and `rx_resume` stay high until they are cleared by `resume_clr` (bit 0 clears transmit, bit 1 clears receive). If a clear and a set fall in the same cycle, the set wins.
- R12: `card_clk_en` is high exactly when a transfer is active and not stalled. While it is low, neither `eng_tx_valid` nor `eng_rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_tx | input | 1 | Start a transmit transfer |
| start_rx | input | 1 | Start a receive transfer |
| xfer_len | input | 8 | Byte count, sampled with a start |
| resume_clr | input | 2 | Clear strobes for the resume flags (bit 0 tx, bit 1 rx) |
| host_wr_valid | input | 1 | Host offers a byte |
| host_wr_ready | output | 1 | Buffer takes a host byte |
| host_wr_data | input | 8 | Host write byte |
| host_rd_valid | output | 1 | Byte available to the host |
| host_rd_ready | input | 1 | Host takes a byte |
| host_rd_data | output | 8 | Oldest buffered byte |
| eng_tx_valid | output | 1 | Byte available to the engine |
| eng_tx_ready | input | 1 | Engine requests a byte (byte boundary) |
| eng_tx_data | output | 8 | Byte for the engine |
| eng_rx_valid | input | 1 | Engine offers a received byte (byte boundary) |
| eng_rx_ready | output | 1 | Buffer takes an engine byte |
| eng_rx_data | input | 8 | Received byte |
| card_clk_en | output | 1 | Card clock enable |
| tx_active | output | 1 | Transmit transfer in progress |
| rx_active | output | 1 | Receive transfer in progress |
| xfer_done | output | 1 | One-cycle pulse at transfer end |
| tx_resume | output | 1 | Sticky transmit-resume flag |
| rx_resume | output | 1 | Sticky receive-resume flag |
| wr_err | output | 1 | Refused host write pulse |
| rd_err | output | 1 | Refused host read pulse |

## Verification
Two operations can meet in the same cycle: a push and a pop of the buffer. In idle, the host writes and reads in the same cycle. During transmit, a host write lands in the cycle the engine takes a byte. During receive, the host keeps reading while the engine keeps storing, both right at the full boundary and while the stall is being released. The bench's queue model applies the pop and then the push in one step and tracks the buffer level independently. Every output is compared against the model on every cycle, so a wrong level, a lost byte, a missed full or empty edge, or a resume flag at the wrong time shows up the cycle it happens.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    XM_IDLE = 2'd0,
    XM_TX   = 2'd1,
    XM_RX   = 2'd2
  } xfer_mode_e;
endpackage

// File: rtl/cfs_store.sv
// Circular byte store with an extra wrap bit on each pointer.
module cfs_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              full,
  output logic              empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0]       wr_ptr, rd_ptr;
  logic              push_ok, pop_ok;

  assign empty     = (wr_ptr == rd_ptr);
  assign full      = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign push_ok   = push && !full;
  assign pop_ok    = pop && !empty;
  assign head_data = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/cfs_xfer_ctrl.sv
// Transfer mode, byte counter, clock stall and resume flags.
module cfs_xfer_ctrl
  import cfs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_tx,
  input  logic             start_rx,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic [1:0]       resume_clr,
  input  logic             buf_empty,
  input  logic             buf_full,
  input  logic             eng_tx_ready,
  input  logic             eng_rx_valid,
  output logic             eng_tx_valid,
  output logic             eng_rx_ready,
  output xfer_mode_e       mode,
  output logic             stalled,
  output logic             xfer_done,
  output logic             tx_resume,
  output logic             rx_resume
);
  xfer_mode_e       mode_q;
  logic [CNT_W-1:0] remain_q;
  logic             stall_q, done_q, txr_q, rxr_q;
  logic             tx_beat, rx_beat, txr_set, rxr_set, last_byte;

  assign eng_tx_valid = (mode_q == XM_TX) && !buf_empty && !stall_q;
  assign eng_rx_ready = (mode_q == XM_RX) && !buf_full && !stall_q;
  assign tx_beat      = eng_tx_valid && eng_tx_ready;
  assign rx_beat      = eng_rx_ready && eng_rx_valid;
  assign last_byte    = (remain_q == CNT_W'(1));
  assign txr_set      = (mode_q == XM_TX) && stall_q && !buf_empty;
  assign rxr_set      = (mode_q == XM_RX) && stall_q && !buf_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= XM_IDLE;
      remain_q <= '0;
      stall_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (mode_q)
        XM_IDLE: begin
          stall_q <= 1'b0;
          if (xfer_len != '0) begin
            if (start_tx) begin
              mode_q   <= XM_TX;
              remain_q <= xfer_len;
            end else if (start_rx) begin
              mode_q   <= XM_RX;
              remain_q <= xfer_len;
            end
          end
        end
        XM_TX: begin
          if (tx_beat) begin
            remain_q <= remain_q - 1'b1;
            if (last_byte) begin
              mode_q <= XM_IDLE;
              done_q <= 1'b1;
            end
          end
          if (!stall_q && eng_tx_ready && buf_empty) stall_q <= 1'b1;
          else if (txr_set)                          stall_q <= 1'b0;
        end
        XM_RX: begin
          if (rx_beat) begin
            remain_q <= remain_q - 1'b1;
            if (last_byte) begin
              mode_q <= XM_IDLE;
              done_q <= 1'b1;
            end
          end
          if (!stall_q && eng_rx_valid && buf_full) stall_q <= 1'b1;
          else if (rxr_set)                         stall_q <= 1'b0;
        end
        default: mode_q <= XM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txr_q <= 1'b0;
      rxr_q <= 1'b0;
    end else begin
      if (txr_set)            txr_q <= 1'b1;
      else if (resume_clr[0]) txr_q <= 1'b0;
      if (rxr_set)            rxr_q <= 1'b1;
      else if (resume_clr[1]) rxr_q <= 1'b0;
    end
  end

  assign mode      = mode_q;
  assign stalled   = stall_q;
  assign xfer_done = done_q;
  assign tx_resume = txr_q;
  assign rx_resume = rxr_q;
endmodule

// File: rtl/cfs_host_guard.sv
// Registers one-cycle pulses for refused host beats.
module cfs_host_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic wr_ready,
  input  logic rd_valid,
  input  logic rd_ready,
  output logic wr_err,
  output logic rd_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_err <= 1'b0;
      rd_err <= 1'b0;
    end else begin
      wr_err <= wr_valid && !wr_ready;
      rd_err <= rd_ready && !rd_valid;
    end
  end
endmodule

// File: rtl/card_fifo_stall.sv
module card_fifo_stall
  import cfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_tx,
  input  logic              start_rx,
  input  logic [CNT_W-1:0]  xfer_len,
  input  logic [1:0]        resume_clr,
  input  logic              host_wr_valid,
  output logic              host_wr_ready,
  input  logic [DATA_W-1:0] host_wr_data,
  output logic              host_rd_valid,
  input  logic              host_rd_ready,
  output logic [DATA_W-1:0] host_rd_data,
  output logic              eng_tx_valid,
  input  logic              eng_tx_ready,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_rx_valid,
  output logic              eng_rx_ready,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic              card_clk_en,
  output logic              tx_active,
  output logic              rx_active,
  output logic              xfer_done,
  output logic              tx_resume,
  output logic              rx_resume,
  output logic              wr_err,
  output logic              rd_err
);
  xfer_mode_e        mode;
  logic              stalled, buf_full, buf_empty;
  logic              host_push, eng_push, do_push, do_pop;
  logic [DATA_W-1:0] push_data, head_data;

  assign tx_active     = (mode == XM_TX);
  assign rx_active     = (mode == XM_RX);
  assign host_wr_ready = !buf_full && !rx_active;
  assign host_rd_valid = !buf_empty && !tx_active;
  assign host_rd_data  = head_data;
  assign eng_tx_data   = head_data;
  assign card_clk_en   = (mode != XM_IDLE) && !stalled;

  assign host_push = host_wr_valid && host_wr_ready;
  assign eng_push  = eng_rx_valid && eng_rx_ready;
  assign do_push   = host_push || eng_push;
  assign push_data = eng_push ? eng_rx_data : host_wr_data;
  assign do_pop    = (host_rd_valid && host_rd_ready) || (eng_tx_valid && eng_tx_ready);

  cfs_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (do_push),
    .push_data (push_data),
    .pop       (do_pop),
    .head_data (head_data),
    .full      (buf_full),
    .empty     (buf_empty)
  );

  cfs_xfer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_tx     (start_tx),
    .start_rx     (start_rx),
    .xfer_len     (xfer_len),
    .resume_clr   (resume_clr),
    .buf_empty    (buf_empty),
    .buf_full     (buf_full),
    .eng_tx_ready (eng_tx_ready),
    .eng_rx_valid (eng_rx_valid),
    .eng_tx_valid (eng_tx_valid),
    .eng_rx_ready (eng_rx_ready),
    .mode         (mode),
    .stalled      (stalled),
    .xfer_done    (xfer_done),
    .tx_resume    (tx_resume),
    .rx_resume    (rx_resume)
  );

  cfs_host_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (host_wr_valid),
    .wr_ready (host_wr_ready),
    .rd_valid (host_rd_valid),
    .rd_ready (host_rd_ready),
    .wr_err   (wr_err),
    .rd_err   (rd_err)
  );
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker (
  input logic clk,
  input logic rst_n,
  input logic host_wr_valid,
  input logic host_wr_ready,
  input logic host_rd_valid,
  input logic host_rd_ready,
  input logic eng_tx_valid,
  input logic eng_tx_ready,
  input logic eng_rx_valid,
  input logic eng_rx_ready,
  input logic card_clk_en,
  input logic tx_active,
  input logic rx_active,
  input logic xfer_done,
  input logic tx_resume,
  input logic rx_resume,
  input logic wr_err,
  input logic rd_err
);
  assert_modes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_active && rx_active));

  assert_gate_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(card_clk_en) && (tx_active || rx_active))
      |-> $past((tx_active && eng_tx_ready) || (rx_active && eng_rx_valid)));

  assert_no_beat_when_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !card_clk_en |-> (!eng_tx_valid && !eng_rx_ready));

  assert_wr_refused_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_valid && !host_wr_ready) |=> wr_err);

  assert_rd_refused_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_ready && !host_rd_valid) |=> rd_err);

  assert_done_leaves_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!tx_active && !rx_active));

  assert_tx_resume_after_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_resume) |-> $past(tx_active && !card_clk_en));

  assert_rx_resume_after_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_resume) |-> $past(rx_active && !card_clk_en));
endmodule

bind card_fifo_stall cfs_checker u_cfs_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_wr_valid (host_wr_valid),
  .host_wr_ready (host_wr_ready),
  .host_rd_valid (host_rd_valid),
  .host_rd_ready (host_rd_ready),
  .eng_tx_valid  (eng_tx_valid),
  .eng_tx_ready  (eng_tx_ready),
  .eng_rx_valid  (eng_rx_valid),
  .eng_rx_ready  (eng_rx_ready),
  .card_clk_en   (card_clk_en),
  .tx_active     (tx_active),
  .rx_active     (rx_active),
  .xfer_done     (xfer_done),
  .tx_resume     (tx_resume),
  .rx_resume     (rx_resume),
  .wr_err        (wr_err),
  .rd_err        (rd_err)
);

// File: tb/card_fifo_stall_bench.sv
module card_fifo_stall_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_tx = 0, start_rx = 0;
  logic [7:0] xfer_len = '0;
  logic [1:0] resume_clr = '0;
  logic       host_wr_valid = 0, host_rd_ready = 0;
  logic [7:0] host_wr_data = '0;
  logic       eng_tx_ready = 0, eng_rx_valid = 0;
  logic [7:0] eng_rx_data = '0;
  logic       host_wr_ready, host_rd_valid, eng_tx_valid, eng_rx_ready;
  logic [7:0] host_rd_data, eng_tx_data;
  logic       card_clk_en, tx_active, rx_active, xfer_done;
  logic       tx_resume, rx_resume, wr_err, rd_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_fifo_stall u_card_fifo_stall (
    .clk(clk), .rst_n(rst_n), .start_tx(start_tx), .start_rx(start_rx),
    .xfer_len(xfer_len), .resume_clr(resume_clr),
    .host_wr_valid(host_wr_valid), .host_wr_ready(host_wr_ready), .host_wr_data(host_wr_data),
    .host_rd_valid(host_rd_valid), .host_rd_ready(host_rd_ready), .host_rd_data(host_rd_data),
    .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
    .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready), .eng_rx_data(eng_rx_data),
    .card_clk_en(card_clk_en), .tx_active(tx_active), .rx_active(rx_active),
    .xfer_done(xfer_done), .tx_resume(tx_resume), .rx_resume(rx_resume),
    .wr_err(wr_err), .rd_err(rd_err)
  );

  // Behavioural reference: mode 0 idle, 1 transmit, 2 receive
  logic [7:0] mq[$];
  int   m_mode = 0, m_cnt = 0;
  bit   m_stall = 0, m_txr = 0, m_rxr = 0, m_done = 0, m_werr = 0, m_rerr = 0;
  logic [7:0] rx_next = 8'h40;
  int   checks = 0, fails = 0;
  bit   finished = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit e_full  = (mq.size() == DEPTH);
    bit e_empty = (mq.size() == 0);
    bit e_rdv   = !e_empty && (m_mode != 1);
    bit e_txv   = (m_mode == 1) && !e_empty && !m_stall;
    chk("R1 host_wr_ready", host_wr_ready, !e_full && (m_mode != 2));
    chk("R2 host_rd_valid", host_rd_valid, e_rdv);
    if (e_rdv) chk("R2 R1 host_rd_data order", host_rd_data, mq[0]);
    chk("R5 eng_tx_valid", eng_tx_valid, e_txv);
    if (e_txv) chk("R5 eng_tx_data", eng_tx_data, mq[0]);
    chk("R8 eng_rx_ready", eng_rx_ready, (m_mode == 2) && !e_full && !m_stall);
    chk("R6 R9 R12 card_clk_en", card_clk_en, (m_mode != 0) && !m_stall);
    chk("R4 tx_active", tx_active, m_mode == 1);
    chk("R4 rx_active", rx_active, m_mode == 2);
    chk("R10 xfer_done", xfer_done, m_done);
    chk("R3 wr_err", wr_err, m_werr);
    chk("R3 rd_err", rd_err, m_rerr);
    chk("R7 R11 tx_resume", tx_resume, m_txr);
    chk("R9 R11 rx_resume", rx_resume, m_rxr);
  endtask

  task automatic model_update();
    bit e_full  = (mq.size() == DEPTH);
    bit e_empty = (mq.size() == 0);
    bit wr_rdy  = !e_full && (m_mode != 2);
    bit rd_vld  = !e_empty && (m_mode != 1);
    bit tx_vld  = (m_mode == 1) && !e_empty && !m_stall;
    bit rx_rdy  = (m_mode == 2) && !e_full && !m_stall;
    bit hw = host_wr_valid && wr_rdy;
    bit hr = host_rd_ready && rd_vld;
    bit tb = tx_vld && eng_tx_ready;
    bit rb = rx_rdy && eng_rx_valid;
    bit txr_set = (m_mode == 1) && m_stall && !e_empty;
    bit rxr_set = (m_mode == 2) && m_stall && !e_full;
    int nmode = m_mode;
    m_werr = host_wr_valid && !wr_rdy;
    m_rerr = host_rd_ready && !rd_vld;
    m_done = 0;
    if (m_mode == 0) begin
      m_stall = 0;
      if (xfer_len != 0 && start_tx) begin nmode = 1; m_cnt = xfer_len; end
      else if (xfer_len != 0 && start_rx) begin nmode = 2; m_cnt = xfer_len; end
    end else begin
      if (tb || rb) begin
        m_cnt--;
        if (m_cnt == 0) begin nmode = 0; m_done = 1; end
      end
      if (m_mode == 1) begin
        if (!m_stall && eng_tx_ready && e_empty) m_stall = 1;
        else if (txr_set) m_stall = 0;
      end else begin
        if (!m_stall && eng_rx_valid && e_full) m_stall = 1;
        else if (rxr_set) m_stall = 0;
      end
    end
    m_mode = nmode;
    if (txr_set) m_txr = 1; else if (resume_clr[0]) m_txr = 0;
    if (rxr_set) m_rxr = 1; else if (resume_clr[1]) m_rxr = 0;
    if (hr || tb) void'(mq.pop_front());
    if (hw) mq.push_back(host_wr_data);
    if (rb) begin mq.push_back(eng_rx_data); rx_next = rx_next + 8'd1; end
  endtask

  // Inputs are set after a falling edge; compare, then take the rising edge.
  task automatic cycle(int n = 1);
    for (int i = 0; i < n; i++) begin
      eng_rx_data = rx_next;
      #1;
      compare_all();
      @(posedge clk);
      model_update();
      @(negedge clk);
    end
  endtask

  task automatic quiet();
    start_tx = 0; start_rx = 0; resume_clr = '0;
    host_wr_valid = 0; host_rd_ready = 0;
    eng_tx_ready = 0; eng_rx_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 compare_all();              // reset state
    rst_n = 1'b1;

    // Idle: host writes, overlapped write and read, reads past empty (R1 R2 R3)
    for (int i = 0; i < 3; i++) begin host_wr_valid = 1; host_wr_data = 8'hA0 + 8'(i); cycle(); end
    host_rd_ready = 1;
    for (int i = 0; i < 2; i++) begin host_wr_data = 8'hB0 + 8'(i); cycle(); end
    host_wr_valid = 0;
    cycle(5);
    quiet(); cycle();

    // Fill past full, then drain past empty (R1 R3)
    host_wr_valid = 1;
    for (int i = 0; i < 19; i++) begin host_wr_data = 8'h10 + 8'(i); cycle(); end
    host_wr_valid = 0; host_rd_ready = 1;
    cycle(18);
    quiet(); cycle();

    // Zero length ignored (R4)
    start_tx = 1; xfer_len = 0; cycle(); quiet(); cycle();

    // Transmit with a stall and resume (R5 R6 R7 R10)
    host_wr_valid = 1;
    for (int i = 0; i < 2; i++) begin host_wr_data = 8'hC0 + 8'(i); cycle(); end
    host_wr_valid = 0;
    start_tx = 1; xfer_len = 8'd6; cycle(); start_tx = 0;
    start_rx = 1; cycle(); start_rx = 0;          // ignored while busy (R4)
    eng_tx_ready = 1; cycle(4);
    host_wr_valid = 1; host_wr_data = 8'hD0; cycle(); host_wr_valid = 0;
    cycle(3);
    host_wr_valid = 1;                            // push while engine pops
    for (int i = 0; i < 3; i++) begin host_wr_data = 8'hE0 + 8'(i); cycle(); end
    host_wr_valid = 0; cycle(6);
    eng_tx_ready = 0;
    resume_clr = 2'b01; cycle(); resume_clr = 0; cycle(2);   // R11
    host_rd_ready = 1; cycle(3); quiet(); cycle();

    // Receive: fill, stall, resume, overlapped reads (R8 R9 R10)
    start_rx = 1; xfer_len = 8'd24; cycle(); start_rx = 0;
    eng_rx_valid = 1; cycle(20);
    host_wr_valid = 1; host_wr_data = 8'h77; cycle(); host_wr_valid = 0;   // refused in receive
    host_rd_ready = 1; cycle(2); host_rd_ready = 0; cycle(4);
    host_rd_ready = 1; cycle(30);
    eng_rx_valid = 0;
    resume_clr = 2'b10; cycle(); quiet(); cycle(2);

    // Both starts together, empty buffer: tx wins and stalls at once,
    // clear held while resume sets (R4 R6 R7 R11)
    start_tx = 1; start_rx = 1; xfer_len = 8'd3; cycle(); start_tx = 0; start_rx = 0;
    eng_tx_ready = 1; resume_clr = 2'b01; cycle(3);
    host_wr_valid = 1;
    for (int i = 0; i < 3; i++) begin host_wr_data = 8'h50 + 8'(i); cycle(); end
    host_wr_valid = 0; cycle(6);
    quiet(); cycle(3);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule